// File: doc/BRIEF.md
# Third-Order Decimating Filter for a 1-Bit Bitstream

This block turns the single-bit output of an oversampling sigma-delta modulator into 15-bit two's-complement samples at a lower, selectable rate. It is a three-stage cascaded integrator-comb filter. The integrators take one new bit on each cycle where `bit_en` is high. The comb section runs once per decimation frame of N accepted bits. The overall response is a sinc-cubed shape, [(1 − z^−N)/(1 − z^−1)]^3, with nulls at every multiple of the output rate.

A 2-bit rate code sets N. The same code also sets the right shift that brings the full-precision result down to 15 bits, so one code sets the output rate and the scaling together. Control is a small state machine with three states:
- `ST_FLUSH`: one cycle in which all filter state is cleared.
- `ST_FILL`: the filter is running, but its first three results are withheld.
- `ST_RUN`: results are delivered.

Transitions:
- Reset leads to `ST_FILL`.
- A rate-code mismatch in `ST_FILL` or `ST_RUN` leads to `ST_FLUSH`.
- `ST_FLUSH` always moves to `ST_FILL`.
- `ST_FILL` moves to `ST_RUN` at its third decimation event.

Top module: `cic3_decimator`

## Requirements
- R1: A bit is accepted only in a cycle with `bit_en` high. An accepted 1 counts as +1 and an accepted 0 counts as −1. Cycles with `bit_en` low change nothing.
- R2: Each delivered result equals the sum over m = 0..3N−3 of h[m]·x[k−m]. Here x[k] is the accepted bit that completes the frame, and h is the convolution of three length-N runs of ones. Bits accepted before the last flush or reset count as zero.
- R3: `rate_code` selects N: 0 → 256, 1 → 128, 2 → 64, 3 → 32. Exactly one decimation event occurs per N accepted bits.
- R4: The full-precision result is shifted right arithmetically (floor) by 3·log2(N) − 14 bits before it is output.
- R5: Shifted values above 16383 are clamped to 16383. An all-ones input therefore yields 16383. An all-zeros input yields exactly −16384 with no clamping.
- R6: `sample_valid` is high for exactly one cycle: the cycle after the clock edge that accepted the frame's N-th bit. `sample_out` carries the result in that cycle.
- R7: After reset, `sample_valid` and `sample_out` are 0 and the block runs at N = 256. The first three decimation events after reset produce no `sample_valid`.
- R8: When `rate_code` differs from the active code, the next two edges accept no bit and all filter state is cleared. The next three decimation events are then withheld, and results from the fourth onward use only bits accepted after the change.
- R9: The integrators are 26 bits wide (3·log2(256)+2) and wrap modulo 2^26. Results stay exact through long runs of one polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 2 | Selects N and output scaling |
| bit_en | input | 1 | Marks a cycle carrying a modulator bit |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = −1 |
| sample_out | output | 15 | Two's-complement decimated result |
| sample_valid | output | 1 | One-cycle strobe for `sample_out` |

## Verification
The hardest condition to reach from the ports is a run long enough that the integrators wrap many times while the comb output must still be exact. The same run also has to land on the single saturating value, which only an unbroken stream of ones at full scale produces. The stimulus reaches this condition with directed runs of several frames of all ones and all zeros at the longest frame length. Between those runs it uses seeded random bitstreams with random `bit_en` gaps and rate changes issued mid-frame. Every delivered sample is compared with a direct convolution against the sinc-cubed kernel, computed in the bench.

// File: rtl/cic3_pkg.sv
package cic3_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } cic_state_t;

    // log2 of the frame length for a given rate code
    function automatic int frame_log2(input logic [1:0] code, input int max_log2);
        return max_log2 - int'(code);
    endfunction

endpackage

// File: rtl/cic3_ctrl.sv
module cic3_ctrl
    import cic3_pkg::*;
#(
    parameter int MAX_LOG2N = 8,
    parameter int DROP_CNT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [1:0]       rate_code,
    output logic [1:0]       act_code,
    output logic             clr,
    output logic             adv,
    output logic             dec,
    output logic             valid_o,
    output cic_state_t       state_o
);
    localparam int DROP_W = $clog2(DROP_CNT + 1);

    cic_state_t             state_q, state_nxt;
    logic [1:0]             act_q;
    logic [MAX_LOG2N-1:0]   cnt_q;
    logic [MAX_LOG2N-1:0]   lim;
    logic [DROP_W-1:0]      drop_q;
    logic                   rate_chg;
    logic                   valid_q;

    assign rate_chg = (rate_code != act_q) && (state_q != ST_FLUSH);
    assign clr      = rate_chg || (state_q == ST_FLUSH);
    assign adv      = bit_en && !clr;
    assign lim      = {MAX_LOG2N{1'b1}} >> act_q;
    assign dec      = adv && (cnt_q == lim);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_FLUSH: state_nxt = ST_FILL;
            ST_FILL: begin
                if (rate_chg)
                    state_nxt = ST_FLUSH;
                else if (dec && (drop_q == DROP_W'(DROP_CNT - 1)))
                    state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (rate_chg)
                    state_nxt = ST_FLUSH;
            end
            default: state_nxt = ST_FLUSH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FILL;
        else
            state_q <= state_nxt;
    end

    // frame and discard bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '0;
            drop_q <= '0;
        end else if (clr) begin
            act_q  <= rate_code;
            cnt_q  <= '0;
            drop_q <= '0;
        end else begin
            if (adv)
                cnt_q <= dec ? '0 : cnt_q + 1'b1;
            if (dec && (state_q == ST_FILL))
                drop_q <= drop_q + 1'b1;
        end
    end

    // output strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= dec && (state_q == ST_RUN);
    end

    assign act_code = act_q;
    assign valid_o  = valid_q;
    assign state_o  = state_q;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R1
    valid_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(bit_en));

    // R8
    flush_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> (cnt_q == '0) && (state_q == ST_FLUSH));

endmodule

// File: rtl/cic3_integ.sv
module cic3_integ #(
    parameter int W     = 26,
    parameter int ORDER = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         bit_in,
    output logic [W-1:0] sum_nxt,
    output logic [W-1:0] tail_q
);
    logic [W-1:0] acc_q [ORDER];
    logic [W-1:0] feed  [ORDER+1];

    // +1 for a one, -1 (all ones) for a zero
    assign feed[0] = bit_in ? W'(1) : {W{1'b1}};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign feed[g+1] = acc_q[g] + feed[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (clr)
                acc_q[g] <= '0;
            else if (adv)
                acc_q[g] <= feed[g+1];
        end
    end

    assign sum_nxt = feed[ORDER];
    assign tail_q  = acc_q[ORDER-1];

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q[0] == '0) && (acc_q[ORDER-1] == '0));

endmodule

// File: rtl/cic3_comb.sv
module cic3_comb #(
    parameter int W     = 26,
    parameter int ORDER = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         dec,
    input  logic [W-1:0] din,
    output logic [W-1:0] res_q
);
    logic [W-1:0] dly_q [ORDER];
    logic [W-1:0] diff  [ORDER+1];

    assign diff[0] = din;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - dly_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dly_q[g] <= '0;
            else if (clr)
                dly_q[g] <= '0;
            else if (dec)
                dly_q[g] <= diff[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (clr)
            res_q <= '0;
        else if (dec)
            res_q <= diff[ORDER];
    end

endmodule

// File: rtl/cic3_scale.sv
module cic3_scale
    import cic3_pkg::*;
#(
    parameter int W         = 26,
    parameter int OUT_W     = 15,
    parameter int ORDER     = 3,
    parameter int MAX_LOG2N = 8
) (
    input  logic [W-1:0]     res,
    input  logic [1:0]       code,
    output logic [OUT_W-1:0] sample
);
    localparam logic signed [W-1:0] MAX_POS = W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [W-1:0] MIN_NEG = -W'(1 << (OUT_W - 1));

    int                  sh;
    logic signed [W-1:0] shifted;

    always_comb begin
        sh = ORDER * frame_log2(code, MAX_LOG2N) - (OUT_W - 1);
        if (sh < 0)
            sh = 0;
        shifted = $signed(res) >>> sh;
        if (shifted > MAX_POS)
            sample = MAX_POS[OUT_W-1:0];
        else if (shifted < MIN_NEG)
            sample = MIN_NEG[OUT_W-1:0];
        else
            sample = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/cic3_decimator.sv
module cic3_decimator
    import cic3_pkg::*;
#(
    parameter int MAX_LOG2N = 8,
    parameter int ORDER     = 3,
    parameter int OUT_W     = 15,
    parameter int DROP_CNT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_code,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [OUT_W-1:0] sample_out,
    output logic             sample_valid
);
    localparam int ACC_W = ORDER * MAX_LOG2N + 2;

    logic             clr, adv, dec;
    logic [1:0]       act_code;
    cic_state_t       state;
    logic [ACC_W-1:0] sum_nxt, tail_q, res_q;
    logic signed [ACC_W:0] full_scale;

    cic3_ctrl #(.MAX_LOG2N(MAX_LOG2N), .DROP_CNT(DROP_CNT)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_code(rate_code),
        .act_code(act_code), .clr(clr), .adv(adv), .dec(dec),
        .valid_o(sample_valid), .state_o(state)
    );

    cic3_integ #(.W(ACC_W), .ORDER(ORDER)) integ_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .bit_in(bit_in),
        .sum_nxt(sum_nxt), .tail_q(tail_q)
    );

    cic3_comb #(.W(ACC_W), .ORDER(ORDER)) comb_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dec(dec), .din(sum_nxt),
        .res_q(res_q)
    );

    cic3_scale #(.W(ACC_W), .OUT_W(OUT_W), .ORDER(ORDER), .MAX_LOG2N(MAX_LOG2N)) scale_i (
        .res(res_q), .code(act_code), .sample(sample_out)
    );

    assign full_scale = (ACC_W+1)'(1) << (ORDER * frame_log2(act_code, MAX_LOG2N));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> ($signed({res_q[ACC_W-1], res_q}) <= full_scale) &&
                         ($signed({res_q[ACC_W-1], res_q}) >= -full_scale));

    // R7
    valid_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(state == ST_RUN));

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> !sample_valid && (tail_q == '0));

endmodule

// File: tb/cic3_decimator_tb.sv
module cic3_decimator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  rate_code;
    logic        bit_en;
    logic        bit_in;
    logic [14:0] sample_out;
    logic        sample_valid;

    always #5 clk = ~clk;

    cic3_decimator dut_i (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .bit_en(bit_en),
        .bit_in(bit_in), .sample_out(sample_out), .sample_valid(sample_valid)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int    cur_l, cur_n, k_cnt, fcnt, frames;
    int    xs [1024];
    int    hk [768];
    string disc_tag;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // R3: code 0..3 -> N = 256,128,64,32; kernel = three boxcars convolved
    function automatic void load_rate(input int code);
        int tri_w [512];
        cur_l = 8 - code;
        cur_n = 1 << cur_l;
        for (int s = 0; s < 2*cur_n - 1; s++)
            tri_w[s] = (s < cur_n) ? s + 1 : 2*cur_n - 1 - s;
        for (int m = 0; m < 3*cur_n - 2; m++) begin
            hk[m] = 0;
            for (int a = 0; a < cur_n; a++)
                if (m - a >= 0 && m - a <= 2*cur_n - 2)
                    hk[m] += tri_w[m - a];
        end
        k_cnt = 0; fcnt = 0; frames = 0;
    endfunction

    function automatic int expect_val();
        int y = 0;
        int q;
        for (int m = 0; m < 3*cur_n - 2; m++)
            if (m < k_cnt)
                y += hk[m] * xs[(k_cnt - 1 - m) % 1024];
        q = y >>> (3*cur_l - 14);          // R4 floor shift
        if (q > 16383)  q = 16383;         // R5 clamp
        if (q < -16384) q = -16384;
        return q;
    endfunction

    task automatic step(input bit b, input bit en, input string req);
        bit exp_v = 0;
        int exp_d = 0;
        @(negedge clk);
        bit_in = b;
        bit_en = en;
        @(posedge clk);
        #2;
        if (en) begin
            xs[k_cnt % 1024] = b ? 1 : -1;   // R1 mapping
            k_cnt++;
            fcnt++;
            if (fcnt == cur_n) begin
                fcnt = 0;
                frames++;
                exp_v = (frames > 3);
                if (exp_v) exp_d = expect_val();
            end
        end
        if (!exp_v && fcnt == 0 && en)
            chk(disc_tag, int'(sample_valid), 0);
        else
            chk("R6", int'(sample_valid), int'(exp_v));
        if (exp_v && sample_valid)
            chk(req, int'($signed(sample_out)), exp_d);
    endtask

    task automatic set_rate(input int code);
        @(negedge clk);
        rate_code = 2'(code);
        bit_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk("R8", int'(sample_valid), 0);
        load_rate(code);
        disc_tag = "R8";
    endtask

    task automatic run_rand(input int nbits, input int p_one, input int p_gap, input string req);
        for (int i = 0; i < nbits; i++) begin
            bit en = (($urandom % 100) >= p_gap);
            step(($urandom % 100) < p_one, en, req);
        end
    endtask

    task automatic run_const(input int nbits, input bit b, input string req);
        for (int i = 0; i < nbits; i++)
            step(b, 1'b1, req);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5731));
        rst_n = 1'b0; rate_code = 2'd0; bit_en = 1'b0; bit_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7 reset state
        chk("R7", int'(sample_valid), 0);
        chk("R7", int'(sample_out), 0);
        load_rate(0);
        disc_tag = "R7";

        // R7 / R2: default N = 256, random bits, continuous enable
        run_rand(6*256, 50, 0, "R2");
        // R9 / R5: long all-ones at N = 256 wraps integrators, clamps
        run_const(6*256, 1'b1, "R9");
        // R5: all zeros gives exact negative full scale
        run_const(4*256, 1'b0, "R5");

        // R3 / R1: N = 32 with enable gaps and biased bits
        set_rate(3);
        run_rand(24*32*2, 70, 40, "R1");
        run_const(5*32, 1'b1, "R5");

        // R4: N = 64 and 128 scaling
        set_rate(2);
        run_rand(10*64, 35, 10, "R4");
        run_rand(37, 50, 0, "R4");            // leave a partial frame
        set_rate(1);                          // R8 mid-frame change
        run_rand(8*128, 55, 20, "R4");
        run_const(4*128, 1'b0, "R5");

        // R8: change mid-frame back to 256 then to 32
        run_rand(50, 50, 0, "R3");
        set_rate(0);
        run_rand(5*256, 45, 0, "R3");
        run_rand(11, 50, 0, "R3");
        set_rate(3);
        run_rand(8*32, 50, 0, "R8");

        done = 1;
        summary();
        $finish;
    end

endmodule